// File: doc/BRIEF.md
# JTAG Command Sequencer with Register Bus

This block drives a JTAG test access port from a simple 32-bit register bus. The host writes one word that packs a start TAP state, an end TAP state and a cycle count. The engine keeps its own copy of the target's TAP state. It works out the TMS path to the start state on its own, clocks the requested number of TCK cycles in that state, and then moves on to the end state. When the start state is Shift-DR or Shift-IR, each counted cycle drives one bit of a preloaded data word onto TDI, lowest bit first. The TDO bit sampled on the same cycle goes into a capture word at the same bit position.

Writes that cause TCK activity (commands, single manual pulses, changes to the tracked state) pass through a small queue, so they run in the order they were written. A status bit shows when the queue is empty and the engine is at rest. A write that arrives while the queue is full is dropped and sets a sticky overflow flag. TCK is derived from the system clock through a programmable even divider.

Top module: `jtag_cmd_engine`

## Requirements
- R1: TAP states are encoded 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. A write to 0x08 queues a command with the end state in bits [3:0], the start state in bits [7:4] and the cycle count in bits [8+:CNT_W]. After the command, both the target TAP and the tracked state (read at 0x20, bits [3:0]) are in the end state.
- R2: A write to 0x0C loads the TDI word that the next queued command will use. On counted cycle i of a Shift-DR or Shift-IR start state, TDI carries bit i of that word (for i < 32). No other TCK cycle in the sequence is clocked in a shift state.
- R3: If the start and end states differ, TMS is 1 on the last counted cycle. If they are equal, TMS holds the state on every counted cycle: 1 in Test-Logic-Reset and 0 elsewhere.
- R4: A command with start = end = Test-Logic-Reset and count 7, issued while tracked in reset, gives exactly 7 TCK pulses, all with TMS = 1. This puts the target in reset from any state.
- R5: Reading 0x0C returns the capture word. The word is cleared when a command starts, and bit i holds the TDO value sampled at the rising TCK edge of counted cycle i in a shift start state.
- R6: Status at 0x10: bit 8 reads 1 only when the queue is empty and the engine is at rest; bit 0 is a sticky overflow flag. The queue holds FIFO_DEPTH (default 4) entries. A queued write that arrives while the queue is full is discarded and sets bit 0.
- R7: Each write to 0x28 gives exactly one TCK pulse with TMS = bit 0 and TDI = bit 1, and advances the tracked state along that TMS value.
- R8: A write to 0x20 sets the tracked state to bits [3:0] and generates no TCK pulse.
- R9: The divider at 0x04 (reset value 4) stores values below 2 as 2 and rounds odd values down to the even value below. TCK is high for exactly divider/2 system clocks per pulse. TMS and TDI change only while TCK is low.
- R10: A count of zero with equal start and end states only moves the TAP to the start state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data toward the target |
| jtag_tdo | input | 1 | Test data from the target |

## Verification
Register reads are combinational, so divider, capture, status and tracked-state values are due in the same cycle as the read address. A queued write reaches the queue at the next clock edge. It changes status within one further cycle, and its TCK activity then takes an amount of time set by the divider. For this reason the bench never samples at a fixed delay after a queued write. It waits at least three cycles and then polls the status bit until the engine reports rest, and only then compares the capture word, the tracked state and the results gathered by a behavioural target TAP model. That model samples TMS and TDI at each rising TCK edge, drives TDO after each falling edge, and counts the system clocks during which TCK is high.

// File: rtl/jtag_eng_pkg.sv
// Shared TAP state encoding, queue entry kinds and the TAP walk functions.
// Assumes the standard sixteen-state JTAG controller.
package jtag_eng_pkg;

    typedef enum logic [3:0] {
        T_RESET   = 4'd0,  T_IDLE    = 4'd1,  T_DRSEL   = 4'd2,  T_DRCAP   = 4'd3,
        T_DRSHIFT = 4'd4,  T_DREX1   = 4'd5,  T_DRPAUSE = 4'd6,  T_DREX2   = 4'd7,
        T_DRUPD   = 4'd8,  T_IRSEL   = 4'd9,  T_IRCAP   = 4'd10, T_IRSHIFT = 4'd11,
        T_IREX1   = 4'd12, T_IRPAUSE = 4'd13, T_IREX2   = 4'd14, T_IRUPD   = 4'd15
    } tap_t;

    typedef enum logic [1:0] {K_CMD = 2'd0, K_MAN = 2'd1, K_SET = 2'd2} kind_t;

    // Next TAP state after one TCK with the given TMS.
    function automatic tap_t tap_next(tap_t s, logic tms);
        case (s)
            T_RESET:   return tms ? T_RESET   : T_IDLE;
            T_IDLE:    return tms ? T_DRSEL   : T_IDLE;
            T_DRSEL:   return tms ? T_IRSEL   : T_DRCAP;
            T_DRCAP:   return tms ? T_DREX1   : T_DRSHIFT;
            T_DRSHIFT: return tms ? T_DREX1   : T_DRSHIFT;
            T_DREX1:   return tms ? T_DRUPD   : T_DRPAUSE;
            T_DRPAUSE: return tms ? T_DREX2   : T_DRPAUSE;
            T_DREX2:   return tms ? T_DRUPD   : T_DRSHIFT;
            T_DRUPD:   return tms ? T_DRSEL   : T_IDLE;
            T_IRSEL:   return tms ? T_RESET   : T_IRCAP;
            T_IRCAP:   return tms ? T_IREX1   : T_IRSHIFT;
            T_IRSHIFT: return tms ? T_IREX1   : T_IRSHIFT;
            T_IREX1:   return tms ? T_IRUPD   : T_IRPAUSE;
            T_IRPAUSE: return tms ? T_IREX2   : T_IRPAUSE;
            T_IREX2:   return tms ? T_IRUPD   : T_IRSHIFT;
            T_IRUPD:   return tms ? T_DRSEL   : T_IDLE;
            default:   return T_RESET;
        endcase
    endfunction

    function automatic logic in_dr_col(tap_t s);
        return (s >= T_DRCAP) && (s <= T_DRUPD);
    endfunction

    function automatic logic in_ir_col(tap_t s);
        return (s >= T_IRCAP) && (s <= T_IRUPD);
    endfunction

    // TMS bit that moves cur one step closer to tgt (tgt != cur).
    // The walk never clocks in a shift state unless the target is that shift state.
    function automatic logic tap_nav(tap_t cur, tap_t tgt);
        if (tgt == T_RESET) return 1'b1;
        case (cur)
            T_RESET:   return 1'b0;
            T_IDLE:    return 1'b1;
            T_DRSEL:   return !in_dr_col(tgt);
            T_IRSEL:   return !in_ir_col(tgt);
            T_DRCAP:   return tgt != T_DRSHIFT;
            T_IRCAP:   return tgt != T_IRSHIFT;
            T_DREX1:   return !(tgt == T_DRPAUSE || tgt == T_DREX2 || tgt == T_DRSHIFT);
            T_IREX1:   return !(tgt == T_IRPAUSE || tgt == T_IREX2 || tgt == T_IRSHIFT);
            T_DREX2:   return tgt != T_DRSHIFT;
            T_IREX2:   return tgt != T_IRSHIFT;
            T_DRUPD,
            T_IRUPD:   return tgt != T_IDLE;
            default:   return 1'b1;
        endcase
    endfunction

    // TMS value that keeps a state where it is.
    function automatic logic tap_hold(tap_t s);
        return s == T_RESET;
    endfunction

    function automatic logic tap_is_shift(tap_t s);
        return (s == T_DRSHIFT) || (s == T_IRSHIFT);
    endfunction

endpackage

// File: rtl/jtag_cmd_fifo.sv
// Queue for bus writes that cause TCK activity.
// Assumes DEPTH is a power of two. A push while full is dropped here; the caller flags it.
module jtag_cmd_fifo #(
    parameter int WIDTH = 66,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/jtag_tck_gen.sv
// Generates one TCK pulse per go request: a low phase and then a high phase of
// `half` system clocks each. TMS/TDI are loaded at the start of the low phase
// and TDO is sampled as TCK rises. Assumes half >= 1 and go only while idle.
module jtag_tck_gen #(
    parameter int HW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          tms_in,
    input  logic          tdi_in,
    input  logic [HW-1:0] half,
    input  logic          tdo,
    output logic          tck,
    output logic          tms,
    output logic          tdi,
    output logic          done,
    output logic          tdo_smp
);
    logic          busy, hi;
    logic [HW-1:0] cnt, half_q;

    // Phase sequencer for one TCK period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0; done <= 1'b0; tdo_smp <= 1'b0;
            busy <= 1'b0; hi <= 1'b0; cnt <= '0; half_q <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                tms    <= tms_in;
                tdi    <= tdi_in;
                half_q <= half;
                busy   <= 1'b1;
                hi     <= 1'b0;
                cnt    <= '0;
            end else if (busy) begin
                if (cnt == half_q - 1'b1) begin
                    cnt <= '0;
                    if (!hi) begin
                        tck     <= 1'b1;
                        hi      <= 1'b1;
                        tdo_smp <= tdo;
                    end else begin
                        tck  <= 1'b0;
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/jtag_cmd_engine.sv
// Register-bus JTAG command sequencer. Decodes host writes, queues TCK-producing
// requests, tracks the target TAP state and walks it through each command.
// Assumes one target TAP and a TCK domain derived from clk.
module jtag_cmd_engine #(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8,
    parameter int DIV_RST    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              jtag_tck,
    output logic              jtag_tms,
    output logic              jtag_tdi,
    input  logic              jtag_tdo
);
    import jtag_eng_pkg::*;

    localparam logic [ADDR_W-1:0] OFF_DIV  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] OFF_MAN  = ADDR_W'(8'h28);
    localparam int CAP_W   = 32;
    localparam int IDX_W   = $clog2(CAP_W);
    localparam int ENT_W   = 2 + 32 + CAP_W;
    localparam int HW      = DIV_W - 1;
    localparam logic [CNT_W-1:0] CAP_LIM = CNT_W'(CAP_W);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    typedef enum logic [2:0] {S_IDLE, S_NAV1, S_RUN, S_NAV2, S_MAN} seq_t;

    seq_t             seq;
    tap_t             cur, st, en;
    logic [CNT_W-1:0] rep, cnt;
    logic [CAP_W-1:0] shdata, cap, data_q;
    logic [DIV_W-1:0] div_q;
    logic             ovf_q, pend, go_q, btms, btdi;
    logic             push, pop, fifo_empty, fifo_full, eng_idle, run_reset;
    logic             bit_done, bit_tdo, run_tms, run_tdi, last_cyc;
    logic [ENT_W-1:0] fifo_din, head;
    kind_t            wr_kind, head_kind;
    logic [31:0]      head_word;
    logic [CAP_W-1:0] head_data;
    logic             unused_head;

    // Queue entry encoding: {kind, written word, TDI word}.
    assign push      = wr_en && (wr_addr == OFF_CMD || wr_addr == OFF_SET || wr_addr == OFF_MAN);
    assign wr_kind   = (wr_addr == OFF_CMD) ? K_CMD : (wr_addr == OFF_MAN) ? K_MAN : K_SET;
    assign fifo_din  = {wr_kind, wr_data, data_q};
    assign pop       = (seq == S_IDLE) && !pend && !fifo_empty;
    assign head_kind = kind_t'(head[ENT_W-1 -: 2]);
    assign head_word = head[CAP_W +: 32];
    assign head_data = head[CAP_W-1:0];
    assign unused_head = ^head_word;

    assign eng_idle  = (seq == S_IDLE) && fifo_empty;
    assign run_reset = (seq == S_RUN) && (st == T_RESET);
    assign last_cyc  = (cnt == rep - 1'b1);
    assign run_tms   = (last_cyc && st != en) ? 1'b1 : tap_hold(st);
    assign run_tdi   = (tap_is_shift(st) && cnt < CAP_LIM) ? shdata[cnt[IDX_W-1:0]] : 1'b0;

    jtag_cmd_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(fifo_din), .pop(pop),
        .dout(head), .empty(fifo_empty), .full(fifo_full)
    );

    jtag_tck_gen #(.HW(HW)) u_tck (
        .clk(clk), .rst_n(rst_n), .go(go_q), .tms_in(btms), .tdi_in(btdi),
        .half(div_q[DIV_W-1:1]), .tdo(jtag_tdo), .tck(jtag_tck), .tms(jtag_tms),
        .tdi(jtag_tdi), .done(bit_done), .tdo_smp(bit_tdo)
    );

    // Directly written registers: TDI word, divider, overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            div_q  <= DIV_W'(DIV_RST);
            ovf_q  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == OFF_DATA) data_q <= wr_data;
            if (wr_en && wr_addr == OFF_DIV)
                div_q <= (wr_data[DIV_W-1:0] < DIV_MIN) ? DIV_MIN : {wr_data[DIV_W-1:1], 1'b0};
            if (push && fifo_full) ovf_q <= 1'b1;
        end
    end

    // Command sequencer: walk to start, run counted cycles, walk to end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq <= S_IDLE; cur <= T_RESET; st <= T_RESET; en <= T_RESET;
            rep <= '0; cnt <= '0; shdata <= '0; cap <= '0;
            pend <= 1'b0; go_q <= 1'b0; btms <= 1'b0; btdi <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (pend) begin
                if (bit_done) begin
                    pend <= 1'b0;
                    cur  <= tap_next(cur, btms);
                    if (seq == S_RUN) begin
                        if (tap_is_shift(st) && cnt < CAP_LIM) cap[cnt[IDX_W-1:0]] <= bit_tdo;
                        cnt <= cnt + 1'b1;
                    end
                    if (seq == S_MAN) seq <= S_IDLE;
                end
            end else begin
                case (seq)
                    S_IDLE: if (!fifo_empty) begin
                        case (head_kind)
                            K_SET: cur <= tap_t'(head_word[3:0]);
                            K_MAN: begin
                                go_q <= 1'b1; pend <= 1'b1;
                                btms <= head_word[0]; btdi <= head_word[1];
                                seq  <= S_MAN;
                            end
                            K_CMD: begin
                                en     <= tap_t'(head_word[3:0]);
                                st     <= tap_t'(head_word[7:4]);
                                rep    <= head_word[8 +: CNT_W];
                                cnt    <= '0;
                                shdata <= head_data;
                                cap    <= '0;
                                seq    <= S_NAV1;
                            end
                            default: ;
                        endcase
                    end
                    S_NAV1: if (cur == st) seq <= S_RUN;
                            else begin go_q <= 1'b1; pend <= 1'b1; btms <= tap_nav(cur, st); btdi <= 1'b0; end
                    S_RUN:  if (cnt == rep) seq <= S_NAV2;
                            else begin go_q <= 1'b1; pend <= 1'b1; btms <= run_tms; btdi <= run_tdi; end
                    S_NAV2: if (cur == en) seq <= S_IDLE;
                            else begin go_q <= 1'b1; pend <= 1'b1; btms <= tap_nav(cur, en); btdi <= 1'b0; end
                    default: seq <= S_IDLE;
                endcase
            end
        end
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFF_DIV:  rd_data[DIV_W-1:0] = div_q;
            OFF_DATA: rd_data = cap;
            OFF_STAT: begin rd_data[8] = eng_idle; rd_data[0] = ovf_q; end
            OFF_SET:  rd_data[3:0] = cur;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/jtag_cmd_engine_chk.sv
// Protocol checks on the sequencer pins and status flags; bound into the top.
module jtag_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tck,
    input logic tms,
    input logic tdi,
    input logic idle,
    input logic ovf,
    input logic push,
    input logic full,
    input logic run_reset
);
    // R9: TMS/TDI only move while TCK is low.
    assert_pins_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R6: reported rest means no TCK pulse in progress.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !tck);

    // R6: overflow flag stays set.
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R6: overflow is raised only by a write into a full queue.
    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(push && full));

    // R4: counted cycles in Test-Logic-Reset clock TMS high.
    assert_reset_tms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_reset && tck) |-> tms);
endmodule

bind jtag_cmd_engine jtag_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tck(jtag_tck), .tms(jtag_tms), .tdi(jtag_tdi),
    .idle(eng_idle), .ovf(ovf_q), .push(push), .full(fifo_full), .run_reset(run_reset)
);

// File: tb/jtag_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module jtag_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        jtag_tck, jtag_tms, jtag_tdi;
    logic        jtag_tdo = 1'b0;

    always #2 clk = ~clk;

    jtag_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .jtag_tck(jtag_tck), .jtag_tms(jtag_tms),
        .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural target TAP: standard next-state lists, index = state code.
    int nx0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    int nx1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int          m_state = 0;
    int          pulses = 0, ones = 0, sh_cnt = 0, hi_cycles = 0;
    logic [31:0] sh_tdi = '0, pat = '0;
    logic        last_tms = 1'b0, last_tdi = 1'b0;

    always @(posedge jtag_tck) begin
        pulses++;
        if (jtag_tms) ones++;
        last_tms = jtag_tms;
        last_tdi = jtag_tdi;
        if (m_state == 4 || m_state == 11) begin
            if (sh_cnt < 32) sh_tdi[sh_cnt] = jtag_tdi;
            sh_cnt++;
        end
        m_state = jtag_tms ? nx1[m_state] : nx0[m_state];
    end

    always @(negedge jtag_tck) if (sh_cnt < 32) jtag_tdo = pat[sh_cnt];

    always @(negedge clk) if (jtag_tck) hi_cycles++;

    // Vectors: {start[79:76], end[75:72], count[71:64], tdi word[63:32], tdo pattern[31:0]}
    localparam logic [79:0] VEC [6] = '{
        {4'd4,  4'd6,  8'd8,  32'h0000_00A5, 32'h0000_003C},
        {4'd11, 4'd13, 8'd5,  32'h0000_0013, 32'h0000_000A},
        {4'd4,  4'd5,  8'd32, 32'hDEAD_BEEF, 32'h1234_5678},
        {4'd11, 4'd1,  8'd3,  32'h0000_0005, 32'h0000_0006},
        {4'd6,  4'd6,  8'd0,  32'h0000_FFFF, 32'h0000_0000},
        {4'd1,  4'd1,  8'd6,  32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic bus_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        s = '0;
        while (!s[8]) bus_rd(8'h10, s);
    endtask

    task automatic clear_obs(input logic [31:0] p);
        pulses = 0; ones = 0; sh_cnt = 0; hi_cycles = 0; sh_tdi = '0;
        pat = p; jtag_tdo = p[0];
    endtask

    function automatic logic [31:0] cmd(input int s, input int e, input int n);
        return (32'(n) << 8) | (32'(s) << 4) | 32'(e);
    endfunction

    task automatic run_cmd(input int s, input int e, input int n);
        bus_wr(8'h08, cmd(s, e, n));
        bus_end();
        wait_idle();
    endtask

    initial begin
        logic [31:0] r, mask;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_rd(8'h10, r); chk("R6 status after reset", r, 32'h100);
        bus_rd(8'h0C, r); chk("R5 capture after reset", r, 32'h0);
        bus_rd(8'h20, r); chk("R1 tracked state after reset", r, 32'h0);
        bus_rd(8'h04, r); chk("R9 divider reset value", r, 32'd4);

        // R4: target starts in Pause-DR, reset command forces reset
        m_state = 6;
        clear_obs('0);
        run_cmd(0, 0, 7);
        chk("R4 reset pulses", 32'(pulses), 32'd7);
        chk("R4 reset TMS high count", 32'(ones), 32'd7);
        chk("R4 target in reset", 32'(m_state), 32'd0);

        // Table of commands, each starting where the previous ended
        for (int i = 0; i < 6; i++) begin
            int s, e, n;
            s = int'(VEC[i][79:76]); e = int'(VEC[i][75:72]); n = int'(VEC[i][71:64]);
            mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
            clear_obs(VEC[i][31:0]);
            bus_wr(8'h0C, VEC[i][63:32]);
            bus_wr(8'h08, cmd(s, e, n));
            bus_end();
            wait_idle();
            chk($sformatf("R1 vec%0d target end state", i), 32'(m_state), 32'(e));
            bus_rd(8'h20, r);
            chk($sformatf("R1 vec%0d tracked end state", i), r, 32'(e));
            chk($sformatf("R2 vec%0d shift-state clocks", i), 32'(sh_cnt),
                (s == 4 || s == 11) ? 32'(n) : 32'd0);
            chk($sformatf("R2 vec%0d TDI bits", i), sh_tdi,
                (s == 4 || s == 11) ? (VEC[i][63:32] & mask) : 32'd0);
            bus_rd(8'h0C, r);
            chk($sformatf("R5 vec%0d capture", i), r,
                (s == 4 || s == 11) ? (VEC[i][31:0] & mask) : 32'd0);
        end

        // R3: Idle held for 10 cycles from Idle, then leave on last cycle
        clear_obs('0);
        run_cmd(1, 1, 10);
        chk("R3 equal states pulses", 32'(pulses), 32'd10);
        chk("R3 equal states TMS high count", 32'(ones), 32'd0);
        clear_obs('0);
        run_cmd(1, 2, 4);
        chk("R3 exit pulses", 32'(pulses), 32'd4);
        chk("R3 exit TMS high count", 32'(ones), 32'd1);
        chk("R3 exit last TMS", 32'(last_tms), 32'd1);
        chk("R3 exit target state", 32'(m_state), 32'd2);

        // R10: from reset, count zero into Idle
        run_cmd(0, 0, 7);
        clear_obs('0);
        run_cmd(1, 1, 0);
        chk("R10 navigate-only pulses", 32'(pulses), 32'd1);
        chk("R10 navigate-only TMS high", 32'(ones), 32'd0);
        bus_rd(8'h20, r); chk("R10 tracked state", r, 32'd1);

        // R8: override tracked state, no TCK
        clear_obs('0);
        bus_wr(8'h20, 32'd6); bus_end(); wait_idle();
        chk("R8 override pulses", 32'(pulses), 32'd0);
        bus_rd(8'h20, r); chk("R8 override readback", r, 32'd6);
        bus_wr(8'h20, 32'd1); bus_end(); wait_idle();

        // R7: manual pulses from Idle
        clear_obs('0);
        bus_wr(8'h28, 32'b10); bus_end(); wait_idle();
        chk("R7 manual pulses", 32'(pulses), 32'd1);
        chk("R7 manual TMS", 32'(last_tms), 32'd0);
        chk("R7 manual TDI", 32'(last_tdi), 32'd1);
        clear_obs('0);
        bus_wr(8'h28, 32'b01); bus_end(); wait_idle();
        chk("R7 manual TMS high", 32'(last_tms), 32'd1);
        chk("R7 manual target state", 32'(m_state), 32'd2);
        bus_rd(8'h20, r); chk("R7 manual tracked state", r, 32'd2);

        // R9: divider rounding and TCK high time
        bus_wr(8'h04, 32'd7); bus_end();
        bus_rd(8'h04, r); chk("R9 odd divider rounded", r, 32'd6);
        bus_wr(8'h04, 32'd1); bus_end();
        bus_rd(8'h04, r); chk("R9 small divider clamped", r, 32'd2);
        bus_wr(8'h04, 32'd6); bus_end();
        clear_obs('0);
        run_cmd(0, 0, 7);
        chk("R9 pulse count from Select-DR", 32'(pulses), 32'd9);
        chk("R9 TCK high clocks", 32'(hi_cycles), 32'(pulses * 3));
        bus_wr(8'h04, 32'd2); bus_end();

        // R6: overflow on sixth back-to-back command
        bus_rd(8'h10, r); chk("R6 no overflow yet", r, 32'h100);
        clear_obs('0);
        for (int k = 0; k < 6; k++) bus_wr(8'h08, cmd(1, 1, 50));
        bus_end();
        wait_idle();
        chk("R6 accepted command pulses", 32'(pulses), 32'd251);
        bus_rd(8'h10, r); chk("R6 overflow flag", r, 32'h101);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule